// File: doc/BRIEF.md
# Tributary Path Alarm Detector

This block watches one low-order tributary, a VC-12, and raises alarms that persist. One strobe per multiframe delivers the two pointer bytes (first and second), a flag saying the pointer interpreter found the pointer valid, the 3-bit signal label and one trace byte. From these inputs the block raises five alarms: tributary AIS, loss of pointer, label mismatch, unequipped and trace mismatch. Each of the first four is debounced by a run counter of its own. The trace alarm is decided once for each complete 16-byte string, and only when the string's CRC-7 checks.

Software loads the expected label and the expected 16-byte trace through a small write port. The block also drives a downstream AIS request. This request is always forced by the four pointer and label alarms. The trace alarm adds to it only when an enable input is high.

Top module: `trib_path_alarm`

## Requirements
- R1: After reset every alarm output and `ais_req` read 0. The expected label resets to 3'b010 and every expected trace byte resets to 8'h00.
- R2: `alm_tu_ais` sets after 8 consecutive strobes with both pointer bytes equal to 8'hFF. It clears after 8 consecutive strobes without that condition. Any strobe that agrees with the current alarm state restarts the count.
- R3: `alm_tu_lop` sets after 8 consecutive strobes with `ptr_ok`=0 and clears after 8 consecutive strobes with `ptr_ok`=1. The restart rule of R2 applies.
- R4: `alm_slm` sets after 5 consecutive strobes whose label differs from the expected label or equals 3'b111 (the path-AIS label). It clears after 5 consecutive strobes without that condition. The restart rule of R2 applies.
- R5: `alm_uneq` sets after 5 consecutive strobes with label 3'b000 and clears after 5 consecutive strobes with any other label. The restart rule of R2 applies.
- R6: A write with `cfg_we`=1 to address 0 through 15 loads expected trace byte 0 through 15. Address 16 loads the expected label from `cfg_wdata[2:0]`. Writes to any other address have no effect.
- R7: A trace byte with bit 7 set starts a string as byte 0, and it restarts a string already in progress. The next 15 strobes with bit 7 clear fill bytes 1 to 15. Bytes with bit 7 clear that arrive outside a string are ignored.
- R8: The CRC-7 of a string is computed with polynomial x^7+x^3+1 and an initial value of 0. It runs MSB first over bytes 0 to 15, with bits [6:0] of byte 0 taken as zero. The result must equal bits [6:0] of byte 0. A string that fails this check leaves `alm_tim` unchanged.
- R9: After a string that passes the CRC check, `alm_tim` takes the value 1 if any of the 16 bytes differs from the expected trace, and 0 otherwise. The new value is visible from the clock edge that registers the string's last byte.
- R10: `ais_req` is 1 when any of `alm_tu_ais`, `alm_tu_lop`, `alm_slm` or `alm_uneq` is 1, or when `alm_tim` and `trc_ais_en` are both 1.
- R11: No alarm changes in a cycle where `mf_valid` is 0, whatever the other data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mf_valid | input | 1 | Once-per-multiframe strobe qualifying the data inputs |
| v1_byte | input | 8 | First pointer byte |
| v2_byte | input | 8 | Second pointer byte |
| ptr_ok | input | 1 | Pointer interpreter reports a valid pointer |
| sig_label | input | 3 | Received signal label |
| j2_byte | input | 8 | Received trace byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| trc_ais_en | input | 1 | Lets the trace alarm add to the AIS request |
| alm_tu_ais | output | 1 | Tributary AIS alarm |
| alm_tu_lop | output | 1 | Loss of pointer alarm |
| alm_slm | output | 1 | Signal label mismatch alarm |
| alm_uneq | output | 1 | Unequipped alarm |
| alm_tim | output | 1 | Trace identifier mismatch alarm |
| ais_req | output | 1 | Downstream AIS request |

## Verification
The directed part stops runs one strobe short of each threshold and breaks them midway. These cases tell a correct run counter apart from a counter that does not restart, and from one that fires a strobe early or late, in both the set and the clear direction. The label is driven with the path-AIS code, the all-zero code and a plain wrong code. These codes tell the mismatch rule apart from the unequipped rule, since 3'b000 must raise both alarms. The trace strings used are: correct and mismatching, mismatching with a broken CRC, matching, and strings cut off by an early start byte. They show whether the CRC gate, the restart of framing and the AIS mask each act on their own. Random phases with skewed probabilities then mix all conditions with random idle gaps, and during the gaps the data inputs are toggled to expose any logic that does not wait for the strobe.

// File: rtl/tpad_pkg.sv
package tpad_pkg;
    localparam int TRC_LEN = 16;
    localparam int LBL_W   = 3;
    localparam int ADDR_W  = 5;

    localparam logic [LBL_W-1:0] LBL_UNEQ  = '0;
    localparam logic [LBL_W-1:0] LBL_PAIS  = '1;
    localparam logic [LBL_W-1:0] LBL_RESET = 3'b010;

    typedef logic [TRC_LEN-1:0][7:0] trace_t;

    // CRC-7 (x^7 + x^3 + 1), MSB first, byte 0 first, CRC field of byte 0 zeroed
    function automatic logic [6:0] crc7_of(input trace_t s);
        logic [6:0] c;
        logic [7:0] b;
        logic       fb;
        c = '0;
        for (int i = 0; i < TRC_LEN; i++) begin
            b = s[i];
            if (i == 0) b[6:0] = '0;
            for (int k = 7; k >= 0; k--) begin
                fb = c[6] ^ b[k];
                c  = {c[5:0], 1'b0};
                if (fb) c = c ^ 7'h09;
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/tpad_persist.sv
module tpad_persist #(
    parameter int THR = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic cond,
    output logic alarm
);
    localparam int CW = $clog2(THR + 1);

    typedef struct packed {
        logic          alarm;
        logic [CW-1:0] run;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            if (cond == st_q.alarm) begin
                st_d.run = '0;
            end else if (st_q.run == CW'(THR - 1)) begin
                st_d.alarm = cond;
                st_d.run   = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm = st_q.alarm;

    // Shared by the R2, R3, R4 and R5 instances
    p_run_below_thr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run < CW'(THR));

    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(st_q.alarm));

    p_flip_needs_disagree_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cond == st_q.alarm) |=> $stable(st_q.alarm));
endmodule

// File: rtl/tpad_trace.sv
module tpad_trace
    import tpad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [7:0]        j2,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic              tim
);
    localparam int IW = $clog2(TRC_LEN);

    typedef struct packed {
        trace_t        exp_s;
        trace_t        cap;
        logic [IW-1:0] idx;
        logic          lock;
        logic          tim;
    } tst_t;

    tst_t   st_d, st_q;
    trace_t rx_s;
    logic   fin, crc_ok, mism;

    always_comb begin
        rx_s              = st_q.cap;
        rx_s[TRC_LEN-1]   = j2;
        fin    = strobe && st_q.lock && !j2[7] && (st_q.idx == IW'(TRC_LEN - 1));
        crc_ok = (crc7_of(rx_s) == rx_s[0][6:0]);
        mism   = (rx_s != st_q.exp_s);
    end

    always_comb begin
        st_d = st_q;
        if (cfg_we && cfg_addr < ADDR_W'(TRC_LEN)) begin
            st_d.exp_s[cfg_addr[IW-1:0]] = cfg_wdata;
        end
        if (strobe) begin
            if (j2[7]) begin
                st_d.cap[0] = j2;
                st_d.idx    = IW'(1);
                st_d.lock   = 1'b1;
            end else if (st_q.lock) begin
                if (fin) begin
                    st_d.lock = 1'b0;
                    st_d.idx  = '0;
                    if (crc_ok) st_d.tim = mism;
                end else begin
                    st_d.cap[st_q.idx] = j2;
                    st_d.idx           = st_q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tim = st_q.tim;

    p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |-> (st_q.idx != '0));

    p_tim_on_string_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.tim) |-> $past(fin && crc_ok));

    p_badcrc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !crc_ok) |=> $stable(st_q.tim));

    p_unlock_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !st_q.lock);
endmodule

// File: rtl/trib_path_alarm.sv
module trib_path_alarm
    import tpad_pkg::*;
#(
    parameter int AIS_MF  = 8,
    parameter int LOP_MF  = 8,
    parameter int SLM_MF  = 5,
    parameter int UNEQ_MF = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mf_valid,
    input  logic [7:0]        v1_byte,
    input  logic [7:0]        v2_byte,
    input  logic              ptr_ok,
    input  logic [LBL_W-1:0]  sig_label,
    input  logic [7:0]        j2_byte,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              trc_ais_en,
    output logic              alm_tu_ais,
    output logic              alm_tu_lop,
    output logic              alm_slm,
    output logic              alm_uneq,
    output logic              alm_tim,
    output logic              ais_req
);
    localparam int NALM = 4;

    function automatic int thr_of(input int g);
        case (g)
            0:       return AIS_MF;
            1:       return LOP_MF;
            2:       return SLM_MF;
            default: return UNEQ_MF;
        endcase
    endfunction

    typedef struct packed {
        logic [LBL_W-1:0] lbl;
    } topst_t;

    topst_t          st_d, st_q;
    logic [NALM-1:0] cond_v;
    logic [NALM-1:0] alm_v;

    always_comb begin
        st_d = st_q;
        if (cfg_we && cfg_addr == ADDR_W'(TRC_LEN)) st_d.lbl = cfg_wdata[LBL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.lbl <= LBL_RESET;
        else        st_q     <= st_d;
    end

    always_comb begin
        cond_v[0] = (v1_byte == 8'hFF) && (v2_byte == 8'hFF);
        cond_v[1] = !ptr_ok;
        cond_v[2] = (sig_label != st_q.lbl) || (sig_label == LBL_PAIS);
        cond_v[3] = (sig_label == LBL_UNEQ);
    end

    for (genvar g = 0; g < NALM; g++) begin : g_persist
        tpad_persist #(.THR(thr_of(g))) u_persist (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (mf_valid),
            .cond   (cond_v[g]),
            .alarm  (alm_v[g])
        );
    end

    tpad_trace u_trace (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (mf_valid),
        .j2        (j2_byte),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .tim       (alm_tim)
    );

    assign alm_tu_ais = alm_v[0];
    assign alm_tu_lop = alm_v[1];
    assign alm_slm    = alm_v[2];
    assign alm_uneq   = alm_v[3];
    assign ais_req    = (|alm_v) || (alm_tim && trc_ais_en);

    p_ais_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|alm_v) |-> ais_req);

    p_tim_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_v == '0 && !trc_ais_en) |-> !ais_req);

    p_label_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_W'(TRC_LEN)) |=> (st_q.lbl == $past(cfg_wdata[LBL_W-1:0])));

    p_uneq_implies_slm_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_valid && sig_label == LBL_UNEQ && st_q.lbl != LBL_UNEQ) |-> cond_v[2]);
endmodule

// File: tb/trib_path_alarm_tb_top.sv
module trib_path_alarm_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mf_valid = 1'b0;
    logic [7:0] v1_byte = 8'h00, v2_byte = 8'h00;
    logic       ptr_ok = 1'b1;
    logic [2:0] sig_label = 3'b010;
    logic [7:0] j2_byte = 8'h00;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       trc_ais_en = 1'b0;
    logic       alm_tu_ais, alm_tu_lop, alm_slm, alm_uneq, alm_tim, ais_req;

    always #10 clk = ~clk;

    trib_path_alarm dut_i (
        .clk(clk), .rst_n(rst_n), .mf_valid(mf_valid), .v1_byte(v1_byte),
        .v2_byte(v2_byte), .ptr_ok(ptr_ok), .sig_label(sig_label), .j2_byte(j2_byte),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .trc_ais_en(trc_ais_en), .alm_tu_ais(alm_tu_ais), .alm_tu_lop(alm_tu_lop),
        .alm_slm(alm_slm), .alm_uneq(alm_uneq), .alm_tim(alm_tim), .ais_req(ais_req)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // reference state
    logic [7:0] exp_t [16];
    logic [2:0] exp_lbl;
    int         mrun [4];
    bit         mst  [4];
    int         thr  [4] = '{8, 8, 5, 5};
    logic [7:0] mcap [16];
    int         midx;
    bit         mlock;
    bit         mtim;
    logic [7:0] jq [$];

    function automatic logic [6:0] ref_crc(input logic [7:0] f [16]);
        logic [6:0] r = 7'd0;
        for (int i = 0; i < 16; i++) begin
            for (int k = 7; k >= 0; k--) begin
                logic bitv;
                bitv = (i == 0 && k < 7) ? 1'b0 : f[i][k];
                if (r[6] ^ bitv) r = {r[5:0], 1'b0} ^ 7'b0001001;
                else             r = {r[5:0], 1'b0};
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        bit ea;
        ea = mst[0] | mst[1] | mst[2] | mst[3] | (mtim & trc_ais_en);
        chk(req, "alm_tu_ais", alm_tu_ais, mst[0]);
        chk(req, "alm_tu_lop", alm_tu_lop, mst[1]);
        chk(req, "alm_slm",    alm_slm,    mst[2]);
        chk(req, "alm_uneq",   alm_uneq,   mst[3]);
        chk(req, "alm_tim",    alm_tim,    mtim);
        chk(req, "ais_req",    ais_req,    ea);
    endtask

    task automatic model_strobe(input logic [7:0] a, input logic [7:0] b, input logic pv,
                                input logic [2:0] lb, input logic [7:0] j);
        bit c [4];
        c[0] = (a == 8'hFF) && (b == 8'hFF);
        c[1] = !pv;
        c[2] = (lb != exp_lbl) || (lb == 3'b111);
        c[3] = (lb == 3'b000);
        for (int i = 0; i < 4; i++) begin
            if (c[i] == mst[i]) mrun[i] = 0;
            else begin
                mrun[i]++;
                if (mrun[i] == thr[i]) begin mst[i] = c[i]; mrun[i] = 0; end
            end
        end
        if (j[7]) begin
            mcap[0] = j; midx = 1; mlock = 1;
        end else if (mlock) begin
            mcap[midx] = j;
            if (midx == 15) begin
                bit d = 0;
                mlock = 0;
                if (ref_crc(mcap) == mcap[0][6:0]) begin
                    for (int i = 0; i < 16; i++) if (mcap[i] != exp_t[i]) d = 1;
                    mtim = d;
                end
            end else midx++;
        end
    endtask

    task automatic send(input string req, input logic [7:0] a, input logic [7:0] b,
                        input logic pv, input logic [2:0] lb, input logic [7:0] j);
        @(negedge clk);
        v1_byte = a; v2_byte = b; ptr_ok = pv; sig_label = lb; j2_byte = j;
        mf_valid = 1'b1;
        @(negedge clk);
        mf_valid = 1'b0;
        model_strobe(a, b, pv, lb, j);
        check_all(req);
    endtask

    task automatic quiet(input string req, input int n);
        for (int i = 0; i < n; i++) send(req, 8'h00, 8'h00, 1'b1, exp_lbl, 8'h00);
    endtask

    task automatic wr(input logic [4:0] ad, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ad < 16) exp_t[ad] = d;
        else if (ad == 16) exp_lbl = d[2:0];
    endtask

    task automatic push_frame(input bit match, input bit bad);
        logic [7:0] f [16];
        for (int i = 0; i < 16; i++) f[i] = match ? exp_t[i] : (8'($urandom) & 8'h7F);
        if (!match) begin
            f[0] = 8'h80;
            f[0] = {1'b1, ref_crc(f)};
        end
        if (bad) f[0][0] = ~f[0][0];
        for (int i = 0; i < 16; i++) jq.push_back(f[i]);
    endtask

    task automatic send_trace(input string req);
        while (jq.size() > 0) send(req, 8'h00, 8'h00, 1'b1, exp_lbl, jq.pop_front());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] et [16];
        void'($urandom(32'h1C0FFEE5));
        exp_lbl = 3'b010;
        for (int i = 0; i < 4; i++) begin mrun[i] = 0; mst[i] = 0; end
        for (int i = 0; i < 16; i++) begin exp_t[i] = 8'h00; mcap[i] = 8'h00; end
        midx = 0; mlock = 0; mtim = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R6: program label 101 and a trace with a correct CRC; junk write to addr 20
        wr(5'd16, 8'h05);
        wr(5'd20, 8'h03);
        for (int i = 0; i < 16; i++) et[i] = (i == 0) ? 8'h80 : 8'h41 + 8'(i);
        et[0] = {1'b1, ref_crc(et)};
        for (int i = 0; i < 16; i++) wr(5'(i), et[i]);
        quiet("R6", 5);
        chk("R6", "alm_slm after label 101 x5", alm_slm, 1'b0);

        // R2 thresholds and restart
        for (int i = 0; i < 7; i++) send("R2", 8'hFF, 8'hFF, 1'b1, exp_lbl, 8'h00);
        chk("R2", "alm_tu_ais after 7", alm_tu_ais, 1'b0);
        send("R2", 8'hFF, 8'hFF, 1'b1, exp_lbl, 8'h00);
        chk("R2", "alm_tu_ais after 8", alm_tu_ais, 1'b1);
        chk("R10", "ais_req with tu_ais", ais_req, 1'b1);
        quiet("R2", 7);
        send("R2", 8'hFF, 8'hFF, 1'b1, exp_lbl, 8'h00);
        chk("R2", "alm_tu_ais after broken clear run", alm_tu_ais, 1'b1);
        send("R2", 8'hFF, 8'h7F, 1'b1, exp_lbl, 8'h00);
        quiet("R2", 7);
        chk("R2", "alm_tu_ais after 8 clear", alm_tu_ais, 1'b0);

        // R3
        for (int i = 0; i < 8; i++) send("R3", 8'h00, 8'h00, 1'b0, exp_lbl, 8'h00);
        chk("R3", "alm_tu_lop after 8", alm_tu_lop, 1'b1);
        quiet("R3", 8);
        chk("R3", "alm_tu_lop cleared", alm_tu_lop, 1'b0);

        // R4: path-AIS label, then broken runs of a wrong label
        for (int i = 0; i < 5; i++) send("R4", 8'h00, 8'h00, 1'b1, 3'b111, 8'h00);
        chk("R4", "alm_slm on label 111", alm_slm, 1'b1);
        chk("R5", "alm_uneq on label 111", alm_uneq, 1'b0);
        quiet("R4", 5);
        for (int i = 0; i < 4; i++) send("R4", 8'h00, 8'h00, 1'b1, 3'b011, 8'h00);
        quiet("R4", 1);
        for (int i = 0; i < 4; i++) send("R4", 8'h00, 8'h00, 1'b1, 3'b011, 8'h00);
        chk("R4", "alm_slm after broken run", alm_slm, 1'b0);
        send("R4", 8'h00, 8'h00, 1'b1, 3'b011, 8'h00);
        chk("R4", "alm_slm after 5", alm_slm, 1'b1);
        quiet("R4", 5);

        // R5
        for (int i = 0; i < 4; i++) send("R5", 8'h00, 8'h00, 1'b1, 3'b000, 8'h00);
        chk("R5", "alm_uneq after 4", alm_uneq, 1'b0);
        send("R5", 8'h00, 8'h00, 1'b1, 3'b000, 8'h00);
        chk("R5", "alm_uneq after 5", alm_uneq, 1'b1);
        quiet("R5", 5);

        // R7, R8, R9, R10: trace
        for (int i = 0; i < 10; i++) send("R7", 8'h00, 8'h00, 1'b1, exp_lbl, 8'h5A);
        push_frame(1'b0, 1'b0);
        send_trace("R9");
        chk("R9", "alm_tim on good mismatching string", alm_tim, 1'b1);
        chk("R10", "ais_req masked", ais_req, 1'b0);
        @(negedge clk); trc_ais_en = 1'b1; @(negedge clk);
        chk("R10", "ais_req unmasked", ais_req, 1'b1);
        push_frame(1'b1, 1'b1);
        send_trace("R8");
        chk("R8", "alm_tim held on bad CRC", alm_tim, 1'b1);
        push_frame(1'b1, 1'b0);
        send_trace("R9");
        chk("R9", "alm_tim cleared on matching string", alm_tim, 1'b0);
        send("R7", 8'h00, 8'h00, 1'b1, exp_lbl, 8'h80);
        for (int i = 0; i < 3; i++) send("R7", 8'h00, 8'h00, 1'b1, exp_lbl, 8'h11);
        push_frame(1'b0, 1'b0);
        send_trace("R7");
        chk("R7", "alm_tim after restarted string", alm_tim, 1'b1);
        push_frame(1'b1, 1'b0);
        send_trace("R9");

        // random phases
        for (int ph = 0; ph < 60; ph++) begin
            int pa, pl, pb;
            pa = $urandom % 100; pl = $urandom % 100; pb = $urandom % 100;
            trc_ais_en = 1'($urandom);
            for (int s = 0; s < 25; s++) begin
                logic [7:0] a, b, j;
                logic [2:0] lb;
                logic pv;
                if (($urandom % 100) < pa) begin a = 8'hFF; b = 8'hFF; end
                else begin a = 8'($urandom); b = ($urandom % 2) ? 8'hFF : 8'($urandom); end
                pv = (($urandom % 100) < pl) ? 1'b0 : 1'b1;
                if (($urandom % 100) < pb) begin
                    case ($urandom % 3)
                        0: lb = 3'b000;
                        1: lb = 3'b111;
                        default: lb = 3'($urandom);
                    endcase
                end else lb = exp_lbl;
                if (jq.size() == 0) begin
                    if (($urandom % 8) == 0) jq.push_back(8'($urandom));
                    push_frame(($urandom % 2) == 1, ($urandom % 5) == 0);
                end
                j = jq.pop_front();
                send("R2 R3 R4 R5 R9 random", a, b, pv, lb, j);
                for (int q = 0; q < int'($urandom % 3); q++) begin
                    @(negedge clk);
                    v1_byte = 8'hFF; v2_byte = 8'hFF; ptr_ok = 1'b0;
                    sig_label = 3'($urandom); j2_byte = 8'($urandom);
                    @(negedge clk);
                    check_all("R11");
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule